// File: doc/BRIEF.md
# Burst-of-Four Data Steering Path

This block connects a narrow double-data-rate data bus to a storage array whose words are four bus beats wide. Every bus edge becomes one cycle of a 2x internal clock, so one beat moves per cycle. For a write, four incoming beats are collected into one wide word and handed to the array in a single operation. For a read, one wide word is fetched in a single access and then sent out a quarter at a time.

The two lowest address bits pick the quarter that moves first. The burst then steps up through the quarters and wraps from 3 to 0, which gives critical-word-first ordering. When the `WIDE_MODE` parameter is 0, the start point is fixed at quarter 0 and the two low address bits are ignored.

Writes follow a late-write scheme. A completed wide word waits in a holding register and reaches the array only when the next write completes. A read that hits the held word merges it lane by lane, so reads and writes stay coherent.

Commands and write beats use valid/ready handshakes. A command is taken when `cmd_valid` and `cmd_ready` are both high, and the master must hold its command until then. A write beat is taken when `wd_valid` and `wd_ready` are both high, and the master may pause a burst by lowering `wd_valid`. Read beats cannot be back-pressured: they arrive at a fixed latency, marked by `rd_valid`.

Top module: `burst4_steer`

## Requirements
- R1: A write is finished only when its fourth beat has been accepted. `cmd_ready` stays low until that beat's cycle, and the four beats always form one wide word that a later read returns complete.
- R2: A command is accepted when `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is high only when no burst is in progress. `wd_ready` is high only while a write burst is collecting beats. A cycle with `wd_valid` low moves no beat and does not end the burst.
- R3: With `WIDE_MODE`=1, write beat k (k = 0..3) lands in quarter (cmd_addr[1:0] + k) mod 4. Quarter q occupies bits [q*DW +: DW] of the wide word.
- R4: After a read command is accepted on clock edge T, `rd_valid` is low after T and high after edge T+1. It then stays high for exactly four consecutive cycles. Beat k of the read carries quarter (start + k) mod 4, where start follows the same rule as for writes.
- R5: With `WIDE_MODE`=0, every burst starts at quarter 0 and cmd_addr[1:0] has no effect. Two addresses that differ only in those bits reach the same wide word in the same order.
- R6: Bit i of `wd_mask` writes byte lane i (bits [8i +: 8]) of that beat. A lane whose mask bit is 0 keeps its previous contents.
- R7: A read returns the newest written data. This holds even when that data is still in the late-write holding register, and each lane is merged according to its own mask.
- R8: `rd_valid` and `wd_ready` are never high in the same cycle, and a new command is only accepted after the previous burst has fully finished.
- R9: After reset, `cmd_ready` is 1, `rd_valid` and `wd_ready` are 0, and every array word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the bus clock, one beat per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block is idle and takes a command |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_addr | input | AW | Beat address; bits [1:0] select the start quarter |
| wd_valid | input | 1 | Write beat offered |
| wd_ready | output | 1 | Write beat taken this cycle if valid |
| wd_data | input | DW | Write beat data |
| wd_mask | input | DW/8 | Per-byte write enable of the beat |
| rd_valid | output | 1 | Read beat present on rd_data |
| rd_data | output | DW | Read beat data |

## Verification
The bench accepts each read on a known clock edge. It then samples `rd_valid` at the falling edge after that edge, where it must be low, and at the falling edge after the next one, where it must be high. This matches the two registers in the path: the fetch stage and the output stage. A monitor checks every falling edge where `rd_valid` is high against a queue of expected beats taken from a reference array. The queue must be empty once `cmd_ready` returns, so a fifth beat or a missing beat is caught. Write completion is checked at the falling edge after the fourth accepted beat, and the stall behaviour is checked during a deliberately idle beat slot. Two instances, one in each mode, receive the same stimulus and are checked against separate references.

// File: rtl/burst4_pkg.sv
package burst4_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WGATHER = 2'd1,
    ST_RFETCH  = 2'd2,
    ST_RBEAT   = 2'd3
  } steer_st_e;
endpackage

// File: rtl/burst_gather.sv
module burst_gather #(
  parameter int DW = 16,
  parameter int NL = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [1:0]      start,
  input  logic            fire,
  input  logic [DW-1:0]   beat_data,
  input  logic [NL-1:0]   beat_mask,
  output logic [4*DW-1:0] full_word,
  output logic [4*NL-1:0] full_mask
);
  logic [1:0]      ptr;
  logic [4*DW-1:0] acc_word;
  logic [4*NL-1:0] acc_mask;

  // next-state view including the beat accepted this cycle
  for (genvar q = 0; q < 4; q++) begin : g_quarter
    always_comb begin
      if (fire && ptr == q[1:0]) begin
        full_word[q*DW +: DW] = beat_data;
        full_mask[q*NL +: NL] = beat_mask;
      end else begin
        full_word[q*DW +: DW] = acc_word[q*DW +: DW];
        full_mask[q*NL +: NL] = acc_mask[q*NL +: NL];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr      <= '0;
      acc_word <= '0;
      acc_mask <= '0;
    end else if (load) begin
      ptr      <= start;
      acc_mask <= '0;
    end else if (fire) begin
      ptr      <= ptr + 2'd1;
      acc_word <= full_word;
      acc_mask <= full_mask;
    end
  end

  AST_GATHER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ptr == $past(ptr) + 2'd1); // R3
endmodule

// File: rtl/word_store.sv
module word_store #(
  parameter int WW = 64,
  parameter int WM = 8,
  parameter int IW = 4,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic [IW-1:0] c_idx,
  input  logic [WW-1:0] c_word,
  input  logic [WM-1:0] c_mask,
  input  logic          rd_en,
  input  logic [IW-1:0] r_idx,
  output logic [WW-1:0] r_word
);
  localparam int DEPTH = 1 << IW;

  logic [WW-1:0] mem [DEPTH];
  logic          pend_valid;
  logic [IW-1:0] pend_idx;
  logic [WW-1:0] pend_word;
  logic [WM-1:0] pend_mask;
  logic [WW-1:0] merged;
  logic          hit;

  assign hit = pend_valid && (pend_idx == r_idx);

  for (genvar l = 0; l < WM; l++) begin : g_lane
    assign merged[l*LW +: LW] = (hit && pend_mask[l]) ? pend_word[l*LW +: LW]
                                                      : mem[r_idx][l*LW +: LW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      pend_valid <= 1'b0;
      pend_idx   <= '0;
      pend_word  <= '0;
      pend_mask  <= '0;
    end else if (commit) begin
      if (pend_valid) begin
        for (int l = 0; l < WM; l++) begin
          if (pend_mask[l]) mem[pend_idx][l*LW +: LW] <= pend_word[l*LW +: LW];
        end
      end
      pend_valid <= 1'b1;
      pend_idx   <= c_idx;
      pend_word  <= c_word;
      pend_mask  <= c_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) r_word <= '0;
    else if (rd_en) r_word <= merged;
  end

  AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> pend_valid && pend_idx == $past(c_idx)); // R7
  AST_NO_RW_MIX: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && rd_en)); // R8
endmodule

// File: rtl/burst_issue.sv
module burst_issue #(
  parameter int DW     = 16,
  parameter bit PRESET = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [1:0]      start,
  input  logic            adv,
  input  logic [4*DW-1:0] word_in,
  output logic [DW-1:0]   beat_out
);
  logic [1:0]    ptr;
  logic [DW-1:0] quarter [4];

  for (genvar q = 0; q < 4; q++) begin : g_split
    assign quarter[q] = word_in[q*DW +: DW];
  end

  assign beat_out = quarter[ptr];

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= start;
    else if (adv)  ptr <= ptr + 2'd1;
  end

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv && $past(adv) |-> ptr == $past(ptr) + 2'd1); // R4
  AST_NARROW_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!PRESET && adv && !$past(adv)) |-> ptr == 2'd0); // R5
endmodule

// File: rtl/burst4_steer.sv
module burst4_steer
  import burst4_pkg::*;
#(
  parameter int DW        = 16,
  parameter int LANE_W    = 8,
  parameter int AW        = 6,
  parameter bit WIDE_MODE = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic                 cmd_write,
  input  logic [AW-1:0]        cmd_addr,
  input  logic                 wd_valid,
  output logic                 wd_ready,
  input  logic [DW-1:0]        wd_data,
  input  logic [DW/LANE_W-1:0] wd_mask,
  output logic                 rd_valid,
  output logic [DW-1:0]        rd_data
);
  localparam int NL = DW / LANE_W;
  localparam int WW = 4 * DW;
  localparam int WM = 4 * NL;
  localparam int IW = AW - 2;

  steer_st_e     st;
  logic [1:0]    cnt;
  logic [1:0]    start_c;
  logic [1:0]    start_q;
  logic [IW-1:0] idx_q;
  logic          accept;
  logic          wd_fire;
  logic          wr_done;
  logic [WW-1:0] g_word;
  logic [WM-1:0] g_mask;
  logic [WW-1:0] r_word;

  if (WIDE_MODE) begin : g_preset
    assign start_c = cmd_addr[1:0];
  end else begin : g_fixed
    assign start_c = 2'b00;
  end

  assign cmd_ready = (st == ST_IDLE);
  assign wd_ready  = (st == ST_WGATHER);
  assign rd_valid  = (st == ST_RBEAT);
  assign accept    = cmd_valid && cmd_ready;
  assign wd_fire   = wd_valid && wd_ready;
  assign wr_done   = wd_fire && (cnt == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      start_q <= '0;
      idx_q   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          idx_q   <= cmd_addr[AW-1:2];
          start_q <= start_c;
          cnt     <= '0;
          st      <= cmd_write ? ST_WGATHER : ST_RFETCH;
        end
        ST_WGATHER: if (wd_fire) begin
          cnt <= cnt + 2'd1;
          if (cnt == 2'd3) st <= ST_IDLE;
        end
        ST_RFETCH: begin
          cnt <= '0;
          st  <= ST_RBEAT;
        end
        default: begin
          cnt <= cnt + 2'd1;
          if (cnt == 2'd3) st <= ST_IDLE;
        end
      endcase
    end
  end

  burst_gather #(.DW(DW), .NL(NL)) u_gather (
    .clk(clk), .rst_n(rst_n),
    .load(accept && cmd_write), .start(start_c),
    .fire(wd_fire), .beat_data(wd_data), .beat_mask(wd_mask),
    .full_word(g_word), .full_mask(g_mask)
  );

  word_store #(.WW(WW), .WM(WM), .IW(IW), .LW(LANE_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .commit(wr_done), .c_idx(idx_q), .c_word(g_word), .c_mask(g_mask),
    .rd_en(st == ST_RFETCH), .r_idx(idx_q), .r_word(r_word)
  );

  burst_issue #(.DW(DW), .PRESET(WIDE_MODE)) u_issue (
    .clk(clk), .rst_n(rst_n),
    .load(st == ST_RFETCH), .start(start_q),
    .adv(rd_valid), .word_in(r_word), .beat_out(rd_data)
  );

  AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wd_ready)); // R8
  AST_CMD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !cmd_ready); // R2
  AST_RD_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && cnt == 2'd3 |=> !rd_valid && cmd_ready); // R4
  AST_WR_END: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> cmd_ready && !wd_ready); // R1
endmodule

// File: tb/tb_burst4_steer.sv
module tb_burst4_steer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_write = 1'b0;
  logic [5:0]  cmd_addr = '0;
  logic        wd_valid = 1'b0;
  logic [15:0] wd_data = '0;
  logic [1:0]  wd_mask = '0;
  logic        cmd_ready_w, wd_ready_w, rd_valid_w;
  logic        cmd_ready_n, wd_ready_n, rd_valid_n;
  logic [15:0] rd_data_w, rd_data_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0] ref_w [16];
  logic [63:0] ref_n [16];
  logic [15:0] q_w [$];
  logic [15:0] q_n [$];

  always #10 clk = ~clk;

  burst4_steer #(.WIDE_MODE(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready_w),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .wd_valid(wd_valid),
    .wd_ready(wd_ready_w), .wd_data(wd_data), .wd_mask(wd_mask),
    .rd_valid(rd_valid_w), .rd_data(rd_data_w));

  burst4_steer #(.WIDE_MODE(1'b0)) dut_n (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready_n),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .wd_valid(wd_valid),
    .wd_ready(wd_ready_n), .wd_data(wd_data), .wd_mask(wd_mask),
    .rd_valid(rd_valid_n), .rd_data(rd_data_n));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected beats as the design drives them
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(!(rd_valid_w && wd_ready_w), "R8", "wide bus overlap", 1, 0);
      if (rd_valid_w) begin
        if (q_w.size() == 0) chk(0, "R4", "wide extra beat", rd_data_w, 0);
        else begin
          logic [15:0] e;
          e = q_w.pop_front();
          chk(rd_data_w == e, "R3/R4 R7", "wide beat", rd_data_w, e);
        end
      end
      if (rd_valid_n) begin
        if (q_n.size() == 0) chk(0, "R5", "narrow extra beat", rd_data_n, 0);
        else begin
          logic [15:0] e;
          e = q_n.pop_front();
          chk(rd_data_n == e, "R5", "narrow beat", rd_data_n, e);
        end
      end
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (!cmd_ready_w) @(negedge clk);
  endtask

  task automatic do_write(input logic [5:0] a, input logic [63:0] beats,
                          input logic [7:0] m, input bit stall);
    for (int k = 0; k < 4; k++) begin
      int qw;
      qw = (a[1:0] + k) % 4;
      for (int l = 0; l < 2; l++) begin
        if (m[k*2+l]) begin
          ref_w[a[5:2]][qw*16+l*8 +: 8] = beats[k*16+l*8 +: 8];
          ref_n[a[5:2]][k*16+l*8 +: 8]  = beats[k*16+l*8 +: 8];
        end
      end
    end
    wait_idle();
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = a;
    @(posedge clk);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      if (k == 3) chk(!cmd_ready_w && !cmd_ready_n, "R1", "busy before 4th beat", cmd_ready_w, 0);
      if (stall && k == 2) begin
        wd_valid = 1'b0;
        chk(wd_ready_w && !cmd_ready_w, "R2", "ready during stall", {wd_ready_w, cmd_ready_w}, 2'b10);
        @(negedge clk);
        chk(wd_ready_w && wd_ready_n, "R2", "stall kept burst open", wd_ready_w, 1);
      end
      wd_valid = 1'b1; wd_data = beats[k*16 +: 16]; wd_mask = m[k*2 +: 2];
      @(posedge clk);
    end
    @(negedge clk);
    wd_valid = 1'b0;
    chk(cmd_ready_w && !wd_ready_w, "R1", "idle after 4th beat", {cmd_ready_w, wd_ready_w}, 2'b10);
  endtask

  task automatic do_read(input logic [5:0] a);
    for (int k = 0; k < 4; k++) begin
      int qw;
      qw = (a[1:0] + k) % 4;
      q_w.push_back(ref_w[a[5:2]][qw*16 +: 16]);
      q_n.push_back(ref_n[a[5:2]][k*16 +: 16]);
    end
    wait_idle();
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = a;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!rd_valid_w && !rd_valid_n, "R4", "no beat one edge after accept", rd_valid_w, 0);
    @(negedge clk);
    chk(rd_valid_w && rd_valid_n, "R4", "first beat two edges after accept", rd_valid_w, 1);
    wait_idle();
    chk(q_w.size() == 0 && q_n.size() == 0, "R4", "four beats delivered", q_w.size(), 0);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin ref_w[i] = '0; ref_n[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready_w && !rd_valid_w && !wd_ready_w, "R9", "reset state",
        {cmd_ready_w, rd_valid_w, wd_ready_w}, 3'b100);
    do_read(6'h08);                                   // R9 zero array
    do_write(6'h05, 64'h4444_3333_2222_1111, 8'hFF, 1'b0);
    do_read(6'h05);                                   // R7 forward from hold
    do_read(6'h04);                                   // R3 offsets
    do_read(6'h06);
    do_read(6'h07);
    do_write(6'h0A, 64'hDDDD_CCCC_BBBB_AAAA, 8'hFF, 1'b1); // R2 stall
    do_read(6'h0A);
    do_read(6'h05);                                   // R1 committed word
    do_write(6'h04, 64'h9999_8888_7777_6666, 8'b01_10_00_11, 1'b0); // R6
    do_read(6'h05);                                   // R7 merge over array
    do_write(6'h30, 64'h0F0F_F0F0_5A5A_A5A5, 8'hFF, 1'b0);
    do_read(6'h04);                                   // R6 after commit
    do_write(6'h13, 64'h1357_2468_ACE0_BDF1, 8'hFF, 1'b0);
    do_read(6'h10);
    do_read(6'h11);
    do_read(6'h12);
    do_read(6'h13);                                   // R5 narrow same word
    do_read(6'h30);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule